// File: doc/BRIEF.md
# Offset and Gain Correction Stage

This block sits after a decimation filter and turns its signed 32-bit conversion words into the final output code. It first subtracts an offset, then applies a full-scale factor. The offset is 24 bits wide and lines up with the upper 24 bits of the data word. The full-scale factor is an unsigned 24-bit fraction whose unity point is 400000h. All arithmetic saturates rather than wraps. The lowest bit of every corrected word is overwritten with the sign. The two clip codes are the exception: 7FFFFFFFh for the positive limit and 80000000h for the negative limit.

Both correction words can be written from a register port and read back on dedicated outputs. Two self-calibration commands load them from the data itself. Each command averages the next 16 valid samples. The offset command stores the average as the new offset. The gain command computes the factor that maps the averaged, offset-corrected input onto a target code. When the filter-mode input marks the stream as coming from the first (sinc) filter stage alone, words pass through untouched.

Top module: `code_trim`

## Requirements
- R1: After reset the offset reads 000000h, the full-scale word reads 400000h, busy is 0 and outValid is 0. With these values every output equals the input with bit 0 replaced by bit 31.
- R2: Every valid input produces exactly one output. outValid rises on the clock edge after the edge that takes the sample, and outData carries that sample's result.
- R3: The offset is subtracted before scaling, after it is shifted left by 8 bits. An offset of 000001h lowers the result by 100h, and FFFFFFh raises it by 100h.
- R4: The result is (difference × full-scale) shifted right arithmetically by 22. The rounding is toward minus infinity. 400000h gives ×1, 800000h gives ×2, 200000h gives ×0.5 and 000000h gives 0.
- R5: Both the difference and the scaled product saturate to the signed 32-bit range. A result at the positive limit leaves as 7FFFFFFFh and one at the negative limit leaves as 80000000h. Any other result has bit 0 replaced by bit 31.
- R6: While filtSinc is 1, outData equals inData bit for bit, with no offset, scaling or bit-0 change.
- R7: calOfsCmd, accepted while idle, sums the next 16 valid inputs. The sum is shifted right arithmetically by 4, and bits 31:8 of that average become the offset. Samples that arrive while the calibration is busy are output with the scaling bypassed.
- R8: calGainCmd, accepted while idle, averages the next 16 offset-corrected differences the same way, giving A. The full-scale word then becomes calTarget × 2^22 / A, truncated toward zero. If A ≤ 0 or the quotient exceeds FFFFFFh it becomes FFFFFFh. If the quotient is negative it becomes 000000h.
- R9: busy is 1 from the edge that accepts a command to the edge that updates the register. While busy, register writes and further commands are ignored and neither correction word changes. If both commands arrive together, the offset calibration runs.
- R10: When idle, regWrOfs or regWrFsc loads regWrData into the matching register on the next edge. Each value is visible on ofsVal or fscVal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inData | input | 32 | Filter output word, two's complement |
| filtSinc | input | 1 | 1 when the stream comes from the sinc stage alone (correction bypassed) |
| regWrOfs | input | 1 | Write strobe for the offset register |
| regWrFsc | input | 1 | Write strobe for the full-scale register |
| regWrData | input | 24 | Register write value |
| calOfsCmd | input | 1 | Start offset self-calibration |
| calGainCmd | input | 1 | Start gain self-calibration |
| calTarget | input | 32 | Target code for gain calibration, signed |
| outValid | output | 1 | Output sample strobe |
| outData | output | 32 | Corrected output code |
| ofsVal | output | 24 | Current offset register |
| fscVal | output | 24 | Current full-scale register |
| busy | output | 1 | Calibration in progress |

## Verification
The assertions assume that filtSinc and calTarget are steady while they matter. filtSinc must be held across the cycle that carries a sample. calTarget must be held through the whole gain calibration, because the quotient is formed only on the update cycle. The stimulus raises commands only in cycles without a valid sample. It changes calTarget and the mode only while the block is idle. Register writes, and a competing command, are issued in the middle of a calibration window on purpose, so that the rule that such requests are ignored is exercised at the ports.

// File: rtl/code_trim_pkg.sv
package code_trim_pkg;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_COLLECT,
    CS_APPLY
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accClr;
    logic accEn;
    logic accSelDiff;
    logic gainBypass;
    logic ldOfs;
    logic ldFsc;
    logic wrOfs;
    logic wrFsc;
  } ctlStrobe_t;

endpackage

// File: rtl/code_trim_ctl.sv
module code_trim_ctl
  import code_trim_pkg::*;
#(
  parameter int CAL_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       calOfsCmd,
  input  logic       calGainCmd,
  input  logic       regWrOfs,
  input  logic       regWrFsc,
  output ctlStrobe_t stb,
  output logic       busy
);

  localparam int NCAL = 1 << CAL_LOG2;
  localparam logic [CAL_LOG2:0] LASTCNT = (CAL_LOG2 + 1)'(NCAL - 1);

  calState_t         state;
  logic              kindGain;
  logic [CAL_LOG2:0] cnt;
  logic              cmdAny;

  assign cmdAny = calOfsCmd | calGainCmd;
  assign busy   = (state != CS_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= CS_IDLE;
      kindGain <= 1'b0;
      cnt      <= '0;
    end else begin
      case (state)
        CS_IDLE: begin
          if (cmdAny) begin
            state    <= CS_COLLECT;
            kindGain <= ~calOfsCmd;
            cnt      <= '0;
          end
        end
        CS_COLLECT: begin
          if (inValid) begin
            cnt <= cnt + 1'b1;
            if (cnt == LASTCNT) state <= CS_APPLY;
          end
        end
        CS_APPLY: state <= CS_IDLE;
        default:  state <= CS_IDLE;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.accClr     = (state == CS_IDLE) && cmdAny;
    stb.accEn      = (state == CS_COLLECT) && inValid;
    stb.accSelDiff = kindGain;
    stb.gainBypass = busy && !kindGain;
    stb.ldOfs      = (state == CS_APPLY) && !kindGain;
    stb.ldFsc      = (state == CS_APPLY) && kindGain;
    stb.wrOfs      = regWrOfs && !busy;
    stb.wrFsc      = regWrFsc && !busy;
  end

  // R9: an idle command is always taken
  a_r9_cmd_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdAny) |=> busy);

  // R7: the sample count never passes the window length
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= (CAL_LOG2 + 1)'(NCAL));

  // R9: a calibration ends with exactly one register load
  a_r9_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldOfs, stb.ldFsc}));

endmodule

// File: rtl/code_trim_dp.sv
module code_trim_dp
  import code_trim_pkg::*;
#(
  parameter int DW       = 32,
  parameter int RW       = 24,
  parameter int CAL_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  input  logic          filtSinc,
  input  logic [RW-1:0] regWrData,
  input  logic [DW-1:0] calTarget,
  input  ctlStrobe_t    stb,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic [RW-1:0] ofsVal,
  output logic [RW-1:0] fscVal
);

  localparam int PW   = DW + RW + 1;
  localparam int FRAC = RW - 2;
  localparam int OSH  = DW - RW;
  localparam int ACW  = DW + CAL_LOG2;
  localparam logic [RW-1:0] UNITY = {2'b01, {(RW - 2){1'b0}}};
  localparam logic [DW-1:0] MAXC  = {1'b0, {(DW - 1){1'b1}}};
  localparam logic [DW-1:0] MINC  = {1'b1, {(DW - 1){1'b0}}};

  function automatic logic [DW-1:0] satTo(input logic signed [PW-1:0] v);
    if ((&v[PW-1:DW-1]) || !(|v[PW-1:DW-1])) return v[DW-1:0];
    else if (v[PW-1]) return MINC;
    else return MAXC;
  endfunction

  logic [RW-1:0]        ofsReg, fscReg;
  logic signed [PW-1:0] ofsWide, inWide, diffWide, diffExt, fscExt;
  logic signed [PW-1:0] prodWide, prodShift;
  logic [DW-1:0]        diffSat, gained, corr, finalCode;

  // correction path
  always_comb begin
    ofsWide   = $signed({{(PW - DW){ofsReg[RW-1]}}, ofsReg, {OSH{1'b0}}});
    inWide    = $signed({{(PW - DW){inData[DW-1]}}, inData});
    diffWide  = inWide - ofsWide;
    diffSat   = satTo(diffWide);
    diffExt   = $signed({{(PW - DW){diffSat[DW-1]}}, diffSat});
    fscExt    = $signed({{(PW - RW){1'b0}}, fscReg});
    prodWide  = diffExt * fscExt;
    prodShift = prodWide >>> FRAC;
    gained    = satTo(prodShift);
    corr      = stb.gainBypass ? diffSat : gained;
    if (corr == MAXC)      finalCode = MAXC;
    else if (corr == MINC) finalCode = MINC;
    else                   finalCode = {corr[DW-1:1], corr[DW-1]};
  end

  // calibration accumulator
  logic signed [ACW-1:0] acc;
  logic [DW-1:0]         accIn;
  logic signed [DW-1:0]  avg;

  assign accIn = stb.accSelDiff ? diffSat : inData;
  assign avg   = DW'(acc >>> CAL_LOG2);

  always_ff @(posedge clk) begin
    if (!rstN)          acc <= '0;
    else if (stb.accClr) acc <= '0;
    else if (stb.accEn)  acc <= acc + $signed({{CAL_LOG2{accIn[DW-1]}}, accIn});
  end

  // gain quotient, formed on the update cycle
  logic signed [PW-1:0] num, den, quot;
  logic [RW-1:0]        newFsc;
  logic                 avgNonPos;

  always_comb begin
    avgNonPos = (avg <= 0);
    num  = $signed({{(PW - DW){calTarget[DW-1]}}, calTarget}) <<< FRAC;
    den  = avgNonPos ? PW'(1) : $signed({{(PW - DW){avg[DW-1]}}, avg});
    quot = num / den;
    if (avgNonPos)            newFsc = '1;
    else if (quot[PW-1])      newFsc = '0;
    else if (|quot[PW-1:RW])  newFsc = '1;
    else                      newFsc = quot[RW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ofsReg <= '0;
      fscReg <= UNITY;
    end else begin
      if (stb.ldOfs)      ofsReg <= avg[DW-1:OSH];
      else if (stb.wrOfs) ofsReg <= regWrData;
      if (stb.ldFsc)      fscReg <= newFsc;
      else if (stb.wrFsc) fscReg <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) outData <= filtSinc ? inData : finalCode;
    end
  end

  assign ofsVal = ofsReg;
  assign fscVal = fscReg;

  // R2: one output per sample, one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_no_extra: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R6: sinc-only words pass unchanged
  a_r6_sinc_pass: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && filtSinc) |=> (outData == $past(inData)));

  // R5: bit 0 mirrors the sign except for the clip codes
  a_r5_lsb_sign: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(filtSinc) && outData != MAXC && outData != MINC)
      |-> (outData[0] == outData[DW-1]));

endmodule

// File: rtl/code_trim.sv
module code_trim
  import code_trim_pkg::*;
#(
  parameter int DW       = 32,
  parameter int RW       = 24,
  parameter int CAL_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  input  logic          filtSinc,
  input  logic          regWrOfs,
  input  logic          regWrFsc,
  input  logic [RW-1:0] regWrData,
  input  logic          calOfsCmd,
  input  logic          calGainCmd,
  input  logic [DW-1:0] calTarget,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic [RW-1:0] ofsVal,
  output logic [RW-1:0] fscVal,
  output logic          busy
);

  ctlStrobe_t stb;

  code_trim_ctl #(.CAL_LOG2(CAL_LOG2)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .calOfsCmd (calOfsCmd),
    .calGainCmd(calGainCmd),
    .regWrOfs  (regWrOfs),
    .regWrFsc  (regWrFsc),
    .stb       (stb),
    .busy      (busy)
  );

  code_trim_dp #(.DW(DW), .RW(RW), .CAL_LOG2(CAL_LOG2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .filtSinc (filtSinc),
    .regWrData(regWrData),
    .calTarget(calTarget),
    .stb      (stb),
    .outValid (outValid),
    .outData  (outData),
    .ofsVal   (ofsVal),
    .fscVal   (fscVal)
  );

  // R9: correction words frozen while a calibration is running
  a_r9_regs_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || ($stable(ofsVal) && $stable(fscVal))));

endmodule

// File: tb/code_trim_bench.sv
module code_trim_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        filtSinc = 1'b0;
  logic        regWrOfs = 1'b0;
  logic        regWrFsc = 1'b0;
  logic [23:0] regWrData = '0;
  logic        calOfsCmd = 1'b0;
  logic        calGainCmd = 1'b0;
  logic [31:0] calTarget = '0;
  logic        outValid;
  logic [31:0] outData;
  logic [23:0] ofsVal;
  logic [23:0] fscVal;
  logic        busy;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  code_trim u_code_trim (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .filtSinc(filtSinc), .regWrOfs(regWrOfs), .regWrFsc(regWrFsc),
    .regWrData(regWrData), .calOfsCmd(calOfsCmd), .calGainCmd(calGainCmd),
    .calTarget(calTarget), .outValid(outValid), .outData(outData),
    .ofsVal(ofsVal), .fscVal(fscVal), .busy(busy)
  );

  // {offset, full-scale, input, expected}
  localparam int NV = 17;
  localparam logic [111:0] VEC [NV] = '{
    {24'h000000, 24'h400000, 32'h00001234, 32'h00001234},  // R4 unity
    {24'h000000, 24'h400000, 32'h00001235, 32'h00001234},  // R5 lsb sign +
    {24'h000000, 24'h400000, 32'hFFFFFF00, 32'hFFFFFF01},  // R5 lsb sign -
    {24'h000001, 24'h400000, 32'h00000300, 32'h00000200},  // R3 +1 offset
    {24'hFFFFFF, 24'h400000, 32'h00000000, 32'h00000100},  // R3 -1 offset
    {24'h000000, 24'h800000, 32'h00001000, 32'h00002000},  // R4 x2
    {24'h000000, 24'h200000, 32'h00001001, 32'h00000800},  // R4 x0.5
    {24'h000000, 24'h200000, 32'hFFFFFFFF, 32'hFFFFFFFF},  // R4 floor
    {24'h000000, 24'h000000, 32'h12345678, 32'h00000000},  // R4 x0
    {24'h000000, 24'h800000, 32'h40000000, 32'h7FFFFFFF},  // R5 +clip
    {24'h000000, 24'h800000, 32'hC0000000, 32'h80000000},  // R5 -limit
    {24'h000000, 24'h800000, 32'hBFFFFFFF, 32'h80000000},  // R5 -clip
    {24'h7FFFFF, 24'h400000, 32'h80000000, 32'h80000000},  // R5 diff -clip
    {24'h800000, 24'h400000, 32'h7FFFFFF0, 32'h7FFFFFFF},  // R5 diff +clip
    {24'h000000, 24'h400000, 32'h7FFFFFFF, 32'h7FFFFFFF},  // R5 max
    {24'h000000, 24'h400000, 32'h7FFFFFFE, 32'h7FFFFFFE},  // R5 below max
    {24'h000000, 24'h600000, 32'h00000010, 32'h00000018}   // R4 x1.5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sendSample(input logic [31:0] v);
    @(negedge clk);
    inValid = 1'b1;
    inData  = v;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic writeOfs(input logic [23:0] v);
    @(negedge clk);
    regWrOfs = 1'b1; regWrData = v;
    @(negedge clk);
    regWrOfs = 1'b0;
  endtask

  task automatic writeFsc(input logic [23:0] v);
    @(negedge clk);
    regWrFsc = 1'b1; regWrData = v;
    @(negedge clk);
    regWrFsc = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 8 && busy; k++) @(negedge clk);
  endtask

  task automatic gainCal(input logic [31:0] sample, input logic [31:0] target);
    calTarget = target;
    @(negedge clk);
    calGainCmd = 1'b1;
    @(negedge clk);
    calGainCmd = 1'b0;
    for (int i = 0; i < 16; i++) sendSample(sample);
    waitIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ofs", {8'h0, ofsVal}, 32'h0);
    check("R1 fsc", {8'h0, fscVal}, 32'h00400000);
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 outValid", {31'h0, outValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ofs after release", {8'h0, ofsVal}, 32'h0);
    sendSample(32'hFFFF0010);
    check("R1 default path", outData, 32'hFFFF0011);
    check("R2 outValid high", {31'h0, outValid}, 32'h1);
    @(negedge clk);
    check("R2 outValid single", {31'h0, outValid}, 32'h0);

    // table walk: R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      writeOfs(VEC[i][111:88]);
      writeFsc(VEC[i][87:64]);
      check("R10 ofs readback", {8'h0, ofsVal}, {8'h0, VEC[i][111:88]});
      sendSample(VEC[i][63:32]);
      check($sformatf("R3/R4/R5 vec%0d", i), outData, VEC[i][31:0]);
    end

    // R6 sinc bypass vs corrected path
    writeOfs(24'h000010);
    writeFsc(24'h800000);
    @(negedge clk); filtSinc = 1'b1;
    sendSample(32'h12345679);
    check("R6 sinc pass", outData, 32'h12345679);
    @(negedge clk); filtSinc = 1'b0;
    sendSample(32'h12345679);
    check("R6 corrected", outData, 32'h24688CF2);

    // R7 offset calibration with gain bypass; R9 ignored requests
    writeOfs(24'h000000);
    @(negedge clk); calOfsCmd = 1'b1;
    @(negedge clk); calOfsCmd = 1'b0;
    check("R9 busy after cmd", {31'h0, busy}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      sendSample(32'h00001000 + 32'(i) * 32'h100);
      if (i == 3) check("R7 gain bypassed", outData, 32'h00001300);
      if (i == 5) begin
        writeFsc(24'h123456);
        @(negedge clk); calGainCmd = 1'b1;
        @(negedge clk); calGainCmd = 1'b0;
      end
    end
    waitIdle();
    check("R7 offset loaded", {8'h0, ofsVal}, 32'h00000017);
    check("R9 write ignored", {8'h0, fscVal}, 32'h00800000);
    repeat (3) @(negedge clk);
    check("R9 command ignored", {31'h0, busy}, 32'h0);

    // R8 gain calibration
    writeFsc(24'h400000);
    calTarget = 32'h00080000;
    @(negedge clk); calGainCmd = 1'b1;
    @(negedge clk); calGainCmd = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sendSample(32'h00041700);
      if (i == 0) check("R8 old gain in use", outData, 32'h00040000);
    end
    waitIdle();
    check("R8 fsc exact", {8'h0, fscVal}, 32'h00800000);
    sendSample(32'h00041700);
    check("R8 new gain applied", outData, 32'h00080000);

    gainCal(32'h00001600, 32'h00080000);
    check("R8 clamp nonpositive avg", {8'h0, fscVal}, 32'h00FFFFFF);
    gainCal(32'h00001703, 32'h00000001);
    check("R8 truncated quotient", {8'h0, fscVal}, 32'h00155555);
    gainCal(32'h00001703, 32'hFFFFFFFF);
    check("R8 negative quotient", {8'h0, fscVal}, 32'h00000000);
    check("R8 offset untouched", {8'h0, ofsVal}, 32'h00000017);

    // R9 both commands together: offset calibration wins
    @(negedge clk); calOfsCmd = 1'b1; calGainCmd = 1'b1;
    @(negedge clk); calOfsCmd = 1'b0; calGainCmd = 1'b0;
    for (int i = 0; i < 16; i++) sendSample(32'h00020000);
    waitIdle();
    check("R9 priority ofs", {8'h0, ofsVal}, 32'h00000200);
    check("R9 priority fsc kept", {8'h0, fscVal}, 32'h00000000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule